// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block produces instruction fetch addresses for a small microcontroller core that uses 14-bit instruction words. It keeps a 13-bit program counter. Software can read and write the low byte of the counter. The upper five bits have no direct access path: they are taken from a separate five-bit high-address latch, and that latch is written on its own strobe. Each cycle the block takes one command, chosen by fixed priority from the strobes presented. The possible commands are: advance sequentially, load the low byte (a computed jump), jump to an 11-bit target, call, return, and interrupt entry.

Calls and interrupt entries save a return address on an eight-entry hardware stack. Returns restore it. The stack pointer is private to the block. When the stack is full, further pushes overwrite the oldest entries and no overflow is flagged. When the stack is empty, further pops simply wrap the pointer. Stack traffic never alters the high-address latch. The fetch address driven to program memory is the counter reduced modulo the implemented memory size, which is a parameter.

Top module: `pc_unit`

## Requirements
- R1: After reset the program counter is 0x0000, so `fetch_o`, `pcl_o` and `lat_o` are all zero. The stack pointer and all stack entries are cleared.
- R2: An advance strobe increments the 13-bit counter by one. It wraps from 0x1FFF to 0x0000.
- R3: `fetch_o` equals the counter modulo `IMPL_WORDS` (default 2048). A counter of 0x1FFE therefore fetches 0x7FE.
- R4: A low-byte write loads the whole counter in one cycle. PC[7:0] takes `pcl_wdata_i` and PC[12:8] takes the latch value held before that edge. `pcl_o` always shows PC[7:0].
- R5: A latch write changes only the latch. The counter holds when no other command is present.
- R6: A call loads PC[10:0] from `tgt_i` and PC[12:11] from latch bits [4:3]. It pushes the address of the next instruction (PC+1).
- R7: A jump loads the counter the same way as a call, but leaves the stack untouched.
- R8: Interrupt entry loads 0x0004 and pushes the current counter value.
- R9: A return loads the most recently pushed entry and pops it, in last-in first-out order.
- R10: Pushes and pops never change the latch.
- R11: The stack is circular with eight entries. The ninth push overwrites the first entry, the tenth overwrites the second, and so on, with no flag.
- R12: A pop on an empty stack wraps the pointer backwards. It returns whatever entry is stored at that slot.
- R13: When several commands are strobed together, one wins in this order: interrupt, return, call, jump, low-byte write, advance. A latch write in the same cycle takes effect alongside the winning command, and the winner sees the old latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Sequential advance strobe |
| goto_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe (covers all return flavours) |
| irq_i | input | 1 | Interrupt entry strobe |
| tgt_i | input | 11 | Jump/call target from the instruction |
| pcl_we_i | input | 1 | Low-byte write strobe |
| pcl_wdata_i | input | 8 | Low-byte write data |
| lat_we_i | input | 1 | High-address latch write strobe |
| lat_wdata_i | input | 5 | High-address latch write data |
| pcl_o | output | 8 | Readable low byte of the counter |
| lat_o | output | 5 | Current high-address latch value |
| fetch_o | output | 13 | Fetch address, wrapped to implemented memory |

## Verification
The bench runs ten calls in a row to force the stack to wrap. It then drains the stack past empty. A design that refused overflowing pushes, or that clamped the pointer, would return the wrong address on the later returns. Computed jumps are issued in the same cycle as latch writes. A design that forwarded the new latch value, or that let stack traffic load the latch, would land on the wrong page. The bench also drives the counter across 0x1FFF and across the 2K fetch boundary, and it stacks up conflicting strobes, so a wrong increment width, a missing fetch wrap, or a wrong priority order each shows up as a fetch-address mismatch.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // One command per cycle, resolved by fixed priority
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_ADV  = 3'd1,
        OP_PCLW = 3'd2,
        OP_GOTO = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5,
        OP_IRQ  = 3'd6
    } pcu_op_e;

endpackage

// File: rtl/pcu_op_decode.sv
module pcu_op_decode
    import pcu_pkg::*;
(
    input  logic    adv_i,
    input  logic    pclw_i,
    input  logic    goto_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    irq_i,
    output pcu_op_e op_o
);

    // Priority: interrupt > return > call > jump > low-byte write > advance (R13)
    always_comb begin
        if (irq_i)       op_o = OP_IRQ;
        else if (ret_i)  op_o = OP_RET;
        else if (call_i) op_o = OP_CALL;
        else if (goto_i) op_o = OP_GOTO;
        else if (pclw_i) op_o = OP_PCLW;
        else if (adv_i)  op_o = OP_ADV;
        else             op_o = OP_HOLD;
    end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]         ptr;
        logic [DEPTH-1:0][W-1:0]  mem;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    // Circular pointer arithmetic, correct for any depth (R11, R12)
    always_comb begin
        ptr_inc = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        ptr_dec = (st_q.ptr == '0) ? LAST : st_q.ptr - 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.ptr] = push_val_i;
            st_d.ptr           = ptr_inc;
        end else if (pop_i) begin
            st_d.ptr = ptr_dec;
        end
        top_o = st_q.mem[ptr_dec];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a push on the last slot wraps to slot zero, no saturation
    p_push_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && st_q.ptr == LAST) |=> (st_q.ptr == '0));

    // R11: pushed value lands in the slot the pointer held
    p_push_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (st_q.mem[$past(st_q.ptr)] == $past(push_val_i)));

    // R12: a pop from slot zero wraps to the last slot
    p_pop_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && st_q.ptr == '0) |=> (st_q.ptr == LAST));

    // R13: decoder never asks for both at once
    p_push_pop_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/pcu_fetch_wrap.sv
module pcu_fetch_wrap #(
    parameter int PC_W       = 13,
    parameter int IMPL_WORDS = 2048
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] fetch_o
);

    localparam int  SPACE  = 1 << PC_W;
    localparam bit  FULL   = (IMPL_WORDS >= SPACE);
    localparam bit  POW2   = ((IMPL_WORDS & (IMPL_WORDS - 1)) == 0);

    generate
        if (FULL) begin : g_full
            assign fetch_o = pc_i;
        end else if (POW2) begin : g_mask
            localparam logic [PC_W-1:0] MASK = PC_W'(IMPL_WORDS - 1);
            assign fetch_o = pc_i & MASK;
        end else begin : g_mod
            localparam logic [PC_W-1:0] SIZE = PC_W'(IMPL_WORDS);
            assign fetch_o = pc_i % SIZE;
        end
    endgenerate

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int TGT_W       = 11,
    parameter int STACK_DEPTH = 8,
    parameter int IMPL_WORDS  = 2048,
    parameter int IRQ_VEC     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               goto_i,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic               irq_i,
    input  logic [TGT_W-1:0]   tgt_i,
    input  logic               pcl_we_i,
    input  logic [7:0]         pcl_wdata_i,
    input  logic               lat_we_i,
    input  logic [PC_W-9:0]    lat_wdata_i,
    output logic [7:0]         pcl_o,
    output logic [PC_W-9:0]    lat_o,
    output logic [PC_W-1:0]    fetch_o
);

    localparam int LAT_W = PC_W - 8;
    localparam int HI_W  = PC_W - TGT_W;
    localparam logic [PC_W-1:0] IRQ_PC = PC_W'(IRQ_VEC);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LAT_W-1:0] lat;
    } pcu_state_t;

    pcu_state_t st_d, st_q;
    pcu_op_e    op;
    logic            push, pop;
    logic [PC_W-1:0] push_val, stk_top, pc_inc, jump_pc;

    pcu_op_decode u_dec (
        .adv_i  (adv_i),
        .pclw_i (pcl_we_i),
        .goto_i (goto_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .irq_i  (irq_i),
        .op_o   (op)
    );

    always_comb begin
        pc_inc   = st_q.pc + 1'b1;
        jump_pc  = {st_q.lat[LAT_W-1 -: HI_W], tgt_i};
        push     = (op == OP_CALL) || (op == OP_IRQ);
        pop      = (op == OP_RET);
        push_val = (op == OP_CALL) ? pc_inc : st_q.pc;

        st_d = st_q;
        unique case (op)
            OP_ADV:  st_d.pc = pc_inc;
            OP_PCLW: st_d.pc = {st_q.lat, pcl_wdata_i};
            OP_GOTO: st_d.pc = jump_pc;
            OP_CALL: st_d.pc = jump_pc;
            OP_RET:  st_d.pc = stk_top;
            OP_IRQ:  st_d.pc = IRQ_PC;
            default: st_d.pc = st_q.pc;
        endcase
        if (lat_we_i) st_d.lat = lat_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pcu_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (push_val),
        .top_o      (stk_top)
    );

    pcu_fetch_wrap #(
        .PC_W       (PC_W),
        .IMPL_WORDS (IMPL_WORDS)
    ) u_wrap (
        .pc_i    (st_q.pc),
        .fetch_o (fetch_o)
    );

    assign pcl_o = st_q.pc[7:0];
    assign lat_o = st_q.lat;

    // R2: a lone advance moves the counter by exactly one
    p_adv_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADV) |=> (st_q.pc == PC_W'($past(st_q.pc) + 1'b1)));

    // R3: fetch address never leaves implemented memory
    p_fetch_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fetch_o) < IMPL_WORDS) || (IMPL_WORDS >= (1 << PC_W)));

    // R4: low-byte write lands the written data
    p_pcl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PCLW) |=> (pcl_o == $past(pcl_wdata_i)));

    // R5: latch write alone leaves the counter where it was
    p_lat_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_we_i && op == OP_HOLD) |=> $stable(st_q.pc));

    // R6: call target low bits come from the instruction
    p_call_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> (st_q.pc[TGT_W-1:0] == $past(tgt_i)));

    // R8: interrupt entry lands on the vector
    p_irq_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IRQ) |=> (fetch_o == IRQ_PC));

    // R10: stack traffic never disturbs the latch
    p_lat_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((push || pop) && !lat_we_i) |=> $stable(lat_o));

endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IMPL       = 2048;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv, gto, cal, ret, irq, pclw, latw;
    logic [10:0] tgt;
    logic [7:0]  pcld;
    logic [4:0]  latd;
    logic [7:0]  pcl_o;
    logic [4:0]  lat_o;
    logic [12:0] fetch_o;

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    int m_pc, m_lat, m_sp;
    int m_stk[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_unit #(.IMPL_WORDS(IMPL)) dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .goto_i(gto), .call_i(cal),
        .ret_i(ret), .irq_i(irq), .tgt_i(tgt), .pcl_we_i(pclw),
        .pcl_wdata_i(pcld), .lat_we_i(latw), .lat_wdata_i(latd),
        .pcl_o(pcl_o), .lat_o(lat_o), .fetch_o(fetch_o)
    );

    task automatic model_reset();
        m_pc = 0; m_lat = 0; m_sp = 0;
        foreach (m_stk[i]) m_stk[i] = 0;
    endtask

    task automatic m_push(int v);
        m_stk[m_sp] = v & 13'h1FFF;
        m_sp = (m_sp + 1) % 8;
    endtask

    function automatic int m_pop();
        m_sp = (m_sp + 7) % 8;
        return m_stk[m_sp];
    endfunction

    task automatic compare(string req);
        int ef, ep, el;
        ef = m_pc % IMPL; ep = m_pc & 8'hFF; el = m_lat;
        checks++;
        if (fetch_o !== 13'(ef) || pcl_o !== 8'(ep) || lat_o !== 5'(el)) begin
            fails++;
            $display("FAIL %s: fetch=%h pcl=%h lat=%h expected fetch=%h pcl=%h lat=%h",
                     req, fetch_o, pcl_o, lat_o, ef, ep, el);
        end
    endtask

    task automatic clear_in();
        adv = 0; gto = 0; cal = 0; ret = 0; irq = 0; pclw = 0; latw = 0;
        tgt = '0; pcld = '0; latd = '0;
    endtask

    // drive strobes at negedge, update model at the edge, compare at next negedge
    task automatic step(logic a, logic g, logic c, logic r, logic i,
                        logic pw, logic lw, int t, int pd, int ld, string req);
        int old_lat;
        adv = a; gto = g; cal = c; ret = r; irq = i; pclw = pw; latw = lw;
        tgt = 11'(t); pcld = 8'(pd); latd = 5'(ld);
        @(posedge clk);
        old_lat = m_lat;
        if (i)       begin m_push(m_pc); m_pc = 4; end
        else if (r)  m_pc = m_pop();
        else if (c)  begin m_push(m_pc + 1); m_pc = ((old_lat >> 3) << 11) | (t & 11'h7FF); end
        else if (g)  m_pc = ((old_lat >> 3) << 11) | (t & 11'h7FF);
        else if (pw) m_pc = (old_lat << 8) | (pd & 8'hFF);
        else if (a)  m_pc = (m_pc + 1) & 13'h1FFF;
        if (lw) m_lat = ld & 5'h1F;
        @(negedge clk);
        clear_in();
        compare(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset state");

        // R2 sequential advance
        repeat (3) step(1,0,0,0,0,0,0,0,0,0,"R2 advance");
        // R5 latch write alone
        step(0,0,0,0,0,0,1,0,0,5'h1F,"R5 latch only");
        // R4 computed jump, R3 fetch wrap at 2K
        step(0,0,0,0,0,1,0,0,8'hFE,0,"R4 low-byte load, R3 wrap");
        step(1,0,0,0,0,0,0,0,0,0,"R3 fetch wrap top");
        step(1,0,0,0,0,0,0,0,0,0,"R2 13-bit rollover");
        // R13 latch write with low-byte write: old latch used
        step(0,0,0,0,0,1,1,0,8'h33,5'h08,"R13 old latch on computed jump");
        // R6 call, R7 goto
        step(0,0,1,0,0,0,0,11'h123,0,0,"R6 call");
        step(0,1,0,0,0,0,0,11'h055,0,0,"R7 goto");
        // R8 interrupt
        step(0,0,0,0,1,0,0,0,0,0,"R8 interrupt vector");
        // R9 LIFO returns, R10 latch untouched
        step(0,0,0,1,0,0,0,0,0,0,"R9 return from irq");
        step(0,0,0,1,0,0,0,0,0,0,"R9 return from call R10");
        // R10: computed jump exposes latch after stack traffic
        step(0,0,0,0,0,1,0,0,8'h10,0,"R10 latch after pops");

        // R11 ten calls wrap the stack
        step(0,0,0,0,0,0,1,0,0,5'h18,"R5 latch set");
        for (int k = 0; k < 10; k++)
            step(0,0,1,0,0,0,0,11'h100 + k*3,0,0,"R11 circular push");
        for (int k = 0; k < 8; k++)
            step(0,0,0,1,0,0,0,0,0,0,"R11 drain after overwrite");
        // R12 underflow pops wrap
        for (int k = 0; k < 3; k++)
            step(0,0,0,1,0,0,0,0,0,0,"R12 underflow pop");

        // R13 priority conflicts
        step(0,0,1,1,0,0,0,11'h2AA,0,0,"R13 return beats call");
        step(0,0,1,0,1,0,0,11'h2AA,0,0,"R13 irq beats call");
        step(1,0,0,0,0,1,0,0,8'h77,0,"R13 low-byte beats advance");
        step(1,1,0,0,0,1,0,11'h3C3,8'h11,0,"R13 goto beats low-byte");
        step(0,0,1,0,0,0,1,11'h0F0,0,5'h00,"R13 call sees old latch");
        step(0,0,0,1,0,0,0,0,0,0,"R9 return after conflict");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare("R1 reset clears");
        step(0,0,0,1,0,0,0,0,0,0,"R12 pop after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule